// File: doc/BRIEF.md
# DMA Multi-Line Interrupt Aggregator

This block gathers event reports from a set of DMA channels and turns them into four level interrupt lines. Every clock cycle each channel may present an event word. A channel whose event word is nonzero marks its bit in a shared channel bitmap. The event bits themselves are accumulated into that channel's sticky status register. The one bitmap is then filtered by four independent per-line enable masks. Each masked result is merged into the sticky status register of that line, and the line is driven high while its status holds any set bit.

Software services the block through a simple 32-bit register port. Each line has an enable register (plain read/write) and a status register (write one to clear). Each channel has a sticky status register (write one to clear) and an interrupt-enable register that keeps only a fixed set of bits. Byte-wide accesses are refused with an error strobe and leave all state untouched. The channel count and the event width are parameters.

Top module: `dmairq_agg`

## Requirements
- R1: After asynchronous reset every line status, line enable, channel status and channel enable register reads 0 and all four `irq` outputs are low.
- R2: A nonzero `ch_evt` word for channel c is ORed into channel c's status register (address 0x080 + 8*c, bits [EVT_W-1:0]) at the next clock edge, and earlier bits stay set.
- R3: At the clock edge after a cycle in which channel c has a nonzero event and bit c of line n's enable register (address 0x018 + 4*n) is set, bit c of line n's status register (address 0x008 + 4*n) is set and `irq[n]` is high.
- R4: A channel event sets bit c only in those lines whose enable has bit c set; other lines keep their status and their `irq` level.
- R5: Writing line n's status register clears exactly the bits written as 1; `irq[n]` stays high while any bit remains and goes low at the edge where the status becomes zero.
- R6: Writing channel c's status register clears exactly the bits written as 1.
- R7: Channel c's enable register (address 0x084 + 8*c) stores only the bits of mask 0x9BE and reads back the stored value.
- R8: Line enable registers store all NUM_CH low bits written and read back the stored value.
- R9: An access with `bus_byte` high raises `bus_err` in the same cycle and changes no register.
- R10: When a write-one-to-clear and a new event hit the same status bit (line or channel) in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_evt | input | NUM_CH*EVT_W | Per-channel event words, channel c in bits [c*EVT_W +: EVT_W] |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte-wide access (refused) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| bus_err | output | 1 | Bad-width access indication |
| irq | output | 4 | Level interrupt lines, registered |

## Verification
The hardest condition to reach is a clear write and a fresh event landing on the same status bit in one clock cycle, because the register port and the event inputs are otherwise driven independently. The bench has a dedicated task that drives a write-one-to-clear and an event pulse together in the same cycle, once for a line status bit and once for a channel status bit. It then reads back that the bit is still set and that the line is still high. Byte-wide writes aimed at live enable and status registers are also driven, to show that a refused access leaves them unchanged.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int unsigned BUS_W          = 32;
   localparam int unsigned ADDR_W         = 12;
   localparam int unsigned LINES          = 4;
   localparam logic [ADDR_W-1:0] LSTAT_BASE = 12'h008;
   localparam logic [ADDR_W-1:0] LEN_BASE   = 12'h018;
   localparam logic [ADDR_W-1:0] CH_BASE    = 12'h080;
   localparam int unsigned CH_STRIDE      = 8;
   localparam int unsigned CH_EN_OFS      = 4;
endpackage

// File: rtl/dmairq_regdec.sv
module dmairq_regdec
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 32
) (
   input  logic              bus_sel,
   input  logic              bus_byte,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [LINES-1:0]  hit_lstat,
   output logic [LINES-1:0]  hit_len,
   output logic [NUM_CH-1:0] hit_cstat,
   output logic [NUM_CH-1:0] hit_cen,
   output logic              bad_width
);
   logic ok;
   assign ok        = bus_sel && !bus_byte;
   assign bad_width = bus_sel && bus_byte;

   for (genvar n = 0; n < LINES; n++) begin : g_line
      localparam logic [ADDR_W-1:0] A_ST = LSTAT_BASE + ADDR_W'(4 * n);
      localparam logic [ADDR_W-1:0] A_EN = LEN_BASE + ADDR_W'(4 * n);
      assign hit_lstat[n] = ok && (bus_addr == A_ST);
      assign hit_len[n]   = ok && (bus_addr == A_EN);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_ST = CH_BASE + ADDR_W'(CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_EN = A_ST + ADDR_W'(CH_EN_OFS);
      assign hit_cstat[c] = ok && (bus_addr == A_ST);
      assign hit_cen[c]   = ok && (bus_addr == A_EN);
   end
endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan #(
   parameter int unsigned EVT_W   = 12,
   parameter logic [EVT_W-1:0] EN_MASK = 12'h9BE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt,
   input  logic             wr_stat,
   input  logic             wr_en,
   input  logic [EVT_W-1:0] wdata,
   output logic [EVT_W-1:0] stat,
   output logic [EVT_W-1:0] en,
   output logic             pend
);
   logic [EVT_W-1:0] clr;
   assign pend = |evt;
   assign clr  = wr_stat ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= (stat & ~clr) | evt;
         if (wr_en) en <= wdata & EN_MASK;
      end
   end
endmodule

// File: rtl/dmairq_line.sv
module dmairq_line #(
   parameter int unsigned NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] bitmap,
   input  logic              wr_stat,
   input  logic              wr_en,
   input  logic [NUM_CH-1:0] wdata,
   output logic [NUM_CH-1:0] stat,
   output logic [NUM_CH-1:0] en,
   output logic              irq
);
   logic [NUM_CH-1:0] clr, nxt;
   assign clr = wr_stat ? wdata : '0;
   assign nxt = (stat & ~clr) | (bitmap & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
         irq  <= 1'b0;
      end else begin
         stat <= nxt;
         irq  <= |nxt;
         if (wr_en) en <= wdata;
      end
   end
endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned EVT_W  = 12,
   parameter logic [EVT_W-1:0] CH_EN_MASK = 12'h9BE
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH*EVT_W-1:0] ch_evt,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic                    bus_byte,
   input  logic [11:0]             bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   output logic                    bus_err,
   output logic [3:0]              irq
);
   if (NUM_CH < 1 || NUM_CH > BUS_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..32");
   end
   if (EVT_W < 1 || EVT_W > BUS_W) begin : g_bad_evt
      $error("EVT_W must lie in 1..32");
   end

   localparam int unsigned LW = LINES * NUM_CH;
   localparam int unsigned CW = NUM_CH * EVT_W;

   logic [LINES-1:0]  hit_lstat, hit_len;
   logic [NUM_CH-1:0] hit_cstat, hit_cen;
   logic [NUM_CH-1:0] bitmap;
   logic [LW-1:0]     line_stat_flat, line_en_flat;
   logic [CW-1:0]     chan_stat_flat, chan_en_flat;

   dmairq_regdec #(.NUM_CH(NUM_CH)) u_dec (
      .bus_sel  (bus_sel),
      .bus_byte (bus_byte),
      .bus_addr (bus_addr),
      .hit_lstat(hit_lstat),
      .hit_len  (hit_len),
      .hit_cstat(hit_cstat),
      .hit_cen  (hit_cen),
      .bad_width(bus_err)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmairq_chan #(.EVT_W(EVT_W), .EN_MASK(CH_EN_MASK)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (ch_evt[c*EVT_W +: EVT_W]),
         .wr_stat(hit_cstat[c] && bus_wr),
         .wr_en  (hit_cen[c] && bus_wr),
         .wdata  (bus_wdata[EVT_W-1:0]),
         .stat   (chan_stat_flat[c*EVT_W +: EVT_W]),
         .en     (chan_en_flat[c*EVT_W +: EVT_W]),
         .pend   (bitmap[c])
      );
   end

   for (genvar n = 0; n < LINES; n++) begin : g_line
      dmairq_line #(.NUM_CH(NUM_CH)) u_line (
         .clk    (clk),
         .rst_n  (rst_n),
         .bitmap (bitmap),
         .wr_stat(hit_lstat[n] && bus_wr),
         .wr_en  (hit_len[n] && bus_wr),
         .wdata  (bus_wdata[NUM_CH-1:0]),
         .stat   (line_stat_flat[n*NUM_CH +: NUM_CH]),
         .en     (line_en_flat[n*NUM_CH +: NUM_CH]),
         .irq    (irq[n])
      );
   end

   // Read mux: decoded hits are one-hot, so an OR tree suffices.
   always_comb begin
      logic [31:0] tmp;
      bus_rdata = '0;
      for (int n = 0; n < LINES; n++) begin
         tmp = '0;
         if (hit_lstat[n]) tmp[NUM_CH-1:0] = line_stat_flat[n*NUM_CH +: NUM_CH];
         if (hit_len[n])   tmp[NUM_CH-1:0] = tmp[NUM_CH-1:0] | line_en_flat[n*NUM_CH +: NUM_CH];
         bus_rdata = bus_rdata | tmp;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         tmp = '0;
         if (hit_cstat[c]) tmp[EVT_W-1:0] = chan_stat_flat[c*EVT_W +: EVT_W];
         if (hit_cen[c])   tmp[EVT_W-1:0] = tmp[EVT_W-1:0] | chan_en_flat[c*EVT_W +: EVT_W];
         bus_rdata = bus_rdata | tmp;
      end
   end
endmodule

// File: rtl/dmairq_agg_chk.sv
module dmairq_agg_chk #(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned EVT_W  = 12,
   parameter logic [EVT_W-1:0] CH_EN_MASK = 12'h9BE
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH*EVT_W-1:0] ch_evt,
   input logic                    bus_sel,
   input logic                    bus_byte,
   input logic [3:0]              irq,
   input logic [4*NUM_CH-1:0]     line_stat_flat,
   input logic [4*NUM_CH-1:0]     line_en_flat,
   input logic [NUM_CH*EVT_W-1:0] chan_stat_flat,
   input logic [NUM_CH*EVT_W-1:0] chan_en_flat
);
   logic [NUM_CH-1:0] evmap;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      assign evmap[c] = |ch_evt[c*EVT_W +: EVT_W];

      // R2 and R10: a fresh event is always present in the sticky channel status.
      assert_chan_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_evt[c*EVT_W +: EVT_W] != '0) |=>
         ((chan_stat_flat[c*EVT_W +: EVT_W] & $past(ch_evt[c*EVT_W +: EVT_W]))
           == $past(ch_evt[c*EVT_W +: EVT_W])));

      assert_chan_en_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_en_flat[c*EVT_W +: EVT_W] & ~CH_EN_MASK) == '0);
   end

   for (genvar n = 0; n < 4; n++) begin : g_l
      // R3 and R10: enabled pending channels land in the line status.
      assert_line_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ((evmap & line_en_flat[n*NUM_CH +: NUM_CH]) != '0) |=>
         ((line_stat_flat[n*NUM_CH +: NUM_CH] & $past(evmap & line_en_flat[n*NUM_CH +: NUM_CH]))
           == $past(evmap & line_en_flat[n*NUM_CH +: NUM_CH])));

      assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq[n] == (line_stat_flat[n*NUM_CH +: NUM_CH] != '0));
   end

   assert_byte_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_byte) |=> ($stable(line_en_flat) && $stable(chan_en_flat)));
endmodule

bind dmairq_agg dmairq_agg_chk #(
   .NUM_CH(NUM_CH), .EVT_W(EVT_W), .CH_EN_MASK(CH_EN_MASK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ch_evt        (ch_evt),
   .bus_sel       (bus_sel),
   .bus_byte      (bus_byte),
   .irq           (irq),
   .line_stat_flat(line_stat_flat),
   .line_en_flat  (line_en_flat),
   .chan_stat_flat(chan_stat_flat),
   .chan_en_flat  (chan_en_flat)
);

// File: tb/tb_dmairq_agg.sv
module tb_dmairq_agg;
   localparam int NUM_CH = 32;
   localparam int EVT_W  = 12;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NUM_CH*EVT_W-1:0] ch_evt = '0;
   logic                    bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
   logic [11:0]             bus_addr = '0;
   logic [31:0]             bus_wdata = '0;
   logic [31:0]             bus_rdata;
   logic                    bus_err;
   logic [3:0]              irq;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dmairq_agg dut (
      .clk(clk), .rst_n(rst_n), .ch_evt(ch_evt),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
   );

   function automatic logic [11:0] a_lst(int n); return 12'h008 + 12'(4*n); endfunction
   function automatic logic [11:0] a_len(int n); return 12'h018 + 12'(4*n); endfunction
   function automatic logic [11:0] a_cst(int c); return 12'h080 + 12'(8*c); endfunction
   function automatic logic [11:0] a_cen(int c); return 12'h084 + 12'(8*c); endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_byte = 0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_byte = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic pulse(int c, logic [EVT_W-1:0] v);
      @(negedge clk);
      ch_evt[c*EVT_W +: EVT_W] = v;
      @(negedge clk);
      ch_evt = '0;
   endtask

   task automatic t_reset();
      for (int n = 0; n < 4; n++) begin
         rchk("R1 line status", a_lst(n), 0);
         rchk("R1 line enable", a_len(n), 0);
      end
      rchk("R1 chan status", a_cst(5), 0);
      rchk("R1 chan enable", a_cen(5), 0);
      chk("R1 irq", {28'd0, irq}, 0);
   endtask

   task automatic t_line_en();
      wr(a_len(0), 32'h0000_0005);
      wr(a_len(1), 32'h0000_0002);
      wr(a_len(2), 32'hFFFF_FFFF);
      wr(a_len(3), 32'h0000_0000);
      rchk("R8 en0", a_len(0), 32'h5);
      rchk("R8 en1", a_len(1), 32'h2);
      rchk("R8 en2", a_len(2), 32'hFFFF_FFFF);
      rchk("R8 en3", a_len(3), 32'h0);
   endtask

   task automatic t_events();
      @(negedge clk);
      ch_evt[0*EVT_W +: EVT_W] = 12'h002;
      ch_evt[1*EVT_W +: EVT_W] = 12'h008;
      @(negedge clk);
      ch_evt = '0;
      chk("R3 irq after event", {28'd0, irq}, 32'h7);
      rchk("R3 line0", a_lst(0), 32'h1);
      rchk("R4 line1 only ch1", a_lst(1), 32'h2);
      rchk("R3 line2", a_lst(2), 32'h3);
      rchk("R4 line3 untouched", a_lst(3), 32'h0);
      rchk("R2 ch0 status", a_cst(0), 32'h002);
      rchk("R2 ch1 status", a_cst(1), 32'h008);
      pulse(0, 12'h020);
      rchk("R2 ch0 accumulate", a_cst(0), 32'h022);
      rchk("R4 line1 after ch0", a_lst(1), 32'h2);
   endtask

   task automatic t_w1c_line();
      wr(a_lst(2), 32'h1);
      rchk("R5 line2 partial", a_lst(2), 32'h2);
      chk("R5 irq2 held", {31'd0, irq[2]}, 1);
      wr(a_lst(2), 32'h2);
      rchk("R5 line2 empty", a_lst(2), 32'h0);
      chk("R5 irq2 low", {31'd0, irq[2]}, 0);
      wr(a_lst(0), 32'h1);
      chk("R5 irq0 low", {31'd0, irq[0]}, 0);
      chk("R5 irq1 unaffected", {31'd0, irq[1]}, 1);
   endtask

   task automatic t_w1c_chan();
      wr(a_cst(0), 32'h020);
      rchk("R6 ch0 partial clear", a_cst(0), 32'h002);
      wr(a_cst(0), 32'hFFF);
      rchk("R6 ch0 cleared", a_cst(0), 32'h000);
   endtask

   task automatic t_chan_en();
      wr(a_cen(3), 32'hFFFF_FFFF);
      rchk("R7 ch3 enable mask", a_cen(3), 32'h9BE);
      wr(a_cen(3), 32'h0000_0041);
      rchk("R7 ch3 enable partial", a_cen(3), 32'h000);
   endtask

   task automatic t_byte();
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_byte = 1; bus_addr = a_len(0); bus_wdata = 32'hFFFF_FFFF;
      #1 chk("R9 bus_err", {31'd0, bus_err}, 1);
      @(negedge clk);
      bus_addr = a_lst(1); bus_wdata = 32'h2;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_byte = 0;
      rchk("R9 en0 unchanged", a_len(0), 32'h5);
      rchk("R9 line1 unchanged", a_lst(1), 32'h2);
      chk("R9 irq1 unchanged", {31'd0, irq[1]}, 1);
   endtask

   task automatic t_race();
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_byte = 0; bus_addr = a_lst(1); bus_wdata = 32'h2;
      ch_evt[1*EVT_W +: EVT_W] = 12'h010;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; ch_evt = '0;
      rchk("R10 line1 event wins", a_lst(1), 32'h2);
      chk("R10 irq1 stays", {31'd0, irq[1]}, 1);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a_cst(1); bus_wdata = 32'h018;
      ch_evt[1*EVT_W +: EVT_W] = 12'h010;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; ch_evt = '0;
      rchk("R10 ch1 event wins", a_cst(1), 32'h010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_line_en();
      t_events();
      t_w1c_line();
      t_w1c_chan();
      t_chan_en();
      t_byte();
      t_race();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule